// File: doc/BRIEF.md
# Control and Status Register Bank with Per-Field Access Policies

This block is a small memory-mapped register bank that sits behind a simple processor slave port. Each request carries a valid strobe, a write flag, a word offset and write data. The bank decodes the offset and applies the access rule of the addressed register. It returns read data through an offset-keyed multiplexer and registers that data, so it is valid in the cycle after the request.

The access rules are not all plain storage. The rules are:
- a full-width control word, with a two-bit FIFO command field that is brought out to the datapath;
- an interrupt status word that hardware events set and software clears by writing ones;
- an enable mask that gates the status word onto one interrupt line;
- a word that accepts only its first write after reset;
- a word whose four byte lanes each follow a different write-modification rule;
- a word that clears itself when read;
- a constant identification word.

Top module: `csr_bank`

## Requirements
- R1: After reset the values are as follows, and `rsp_rdata` and `irq` are 0:
  - offset 0 reads 0x20001C8C;
  - offset 4 reads 0x00FF0000;
  - offset 6 reads the ID parameter (default 0x5A170C3E);
  - every other mapped offset reads 0.
- R2: A register changes on a write only when `req_valid` is 1, `req_write` is 1 and `req_addr` equals its offset. A request with `req_valid` low changes nothing.
- R3: A read request (`req_valid`=1, `req_write`=0) loads `rsp_rdata` at the next clock edge. The loaded value is the addressed register's value before any read side effect. `rsp_rdata` holds its value in cycles without a read. Offsets 7 and above read 0, and writes to them change nothing.
- R4: Offset 0 is read-write over all 32 bits. Output `fifo_mode` shows its bits 29:28 with this encoding: 0 = reset FIFO, 1 = flush FIFO, 2 = transmit enable, 3 = receive enable.
- R5: The status word at offset 1 has 8 bits. Bit i is set in the cycle after `hw_event[i]` is 1. Writing a 1 to bit i clears that bit. Writing a 0 leaves it unchanged. An event in the same cycle as a clear of the same bit leaves the bit set.
- R6: Offset 2 is a read-write 8-bit enable mask. `irq` is 1 exactly when some status bit and the matching enable bit are both 1.
- R7: Offset 3 accepts only the first write after reset. Later writes are ignored.
- R8: The byte lanes of offset 4 follow these rules, applied per bit to the current value:
  - bits 7:0 set where the write data is 1;
  - bits 15:8 toggle where the write data is 1;
  - bits 23:16 clear where the write data is 0;
  - bits 31:24 toggle where the write data is 0.
- R9: Offset 5 is writable. A read of offset 5 returns the stored value and clears the stored value to 0 once.
- R10: Offset 6 is read-only. Writes to it are ignored.
- R11: A reset asserted in the middle of operation restores every value in R1 and re-arms the write-once word at offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word offset |
| req_wdata | input | 32 | Write data |
| hw_event | input | 8 | Per-bit status set events |
| rsp_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| fifo_mode | output | 2 | Control bits 29:28 |

## Verification
The bench builds the bank with its default values:
- 32-bit data;
- a 4-bit offset, which leaves nine unmapped offsets available for the R3 checks;
- 8 event inputs, so every status and enable bit can be driven and compared one by one.

At these sizes every byte lane of the modify-rule word is reachable with hand-picked patterns. A mid-run reset also brings the re-arming of the write-once word within reach.

// File: rtl/csr_pkg.sv
package csr_pkg;

  typedef enum logic [2:0] {
    POL_RW    = 3'd0,
    POL_WONCE = 3'd1,
    POL_W1S   = 3'd2,
    POL_W1T   = 3'd3,
    POL_W0C   = 3'd4,
    POL_W0T   = 3'd5
  } policy_e;

  typedef enum logic [1:0] {
    FM_RESET = 2'd0,
    FM_FLUSH = 2'd1,
    FM_TX_EN = 2'd2,
    FM_RX_EN = 2'd3
  } fifo_mode_e;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_EN    = 2;
  localparam int OFS_ONCE  = 3;
  localparam int OFS_MIX   = 4;
  localparam int OFS_RDCLR = 5;
  localparam int OFS_ID    = 6;
  localparam int NUM_REGS  = 7;

  function automatic policy_e mix_lane_policy(input int lane);
    case (lane)
      0:       return POL_W1S;
      1:       return POL_W1T;
      2:       return POL_W0C;
      default: return POL_W0T;
    endcase
  endfunction

endpackage

// File: rtl/csr_field.sv
module csr_field #(
  parameter int               W     = 8,
  parameter logic [W-1:0]     RST   = '0,
  parameter csr_pkg::policy_e POL   = csr_pkg::POL_RW,
  parameter bit               RDCLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         re,
  output logic [W-1:0] value
);
  import csr_pkg::*;

  logic [W-1:0] v_q, v_d;
  logic         wr_ok;

  generate
    if (POL == POL_WONCE) begin : g_once
      logic done_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  done_q <= 1'b0;
        else if (we) done_q <= 1'b1;
      end
      assign wr_ok = we & ~done_q;
      // R7
      once_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && we) |=> (v_q == $past(v_q)));
    end else begin : g_plain
      assign wr_ok = we;
    end
  endgenerate

  always_comb begin
    v_d = v_q;
    if (wr_ok) begin
      case (POL)
        POL_W1S: v_d = v_q | wdata;
        POL_W1T: v_d = v_q ^ wdata;
        POL_W0C: v_d = v_q & wdata;
        POL_W0T: v_d = v_q ^ ~wdata;
        default: v_d = wdata;
      endcase
    end
    if (RDCLR && re) v_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              v_q <= RST;
    else if (wr_ok || re)    v_q <= v_d;
  end

  assign value = v_q;

  generate
    if (RDCLR) begin : g_rdclr_chk
      // R9
      rdclr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> (v_q == '0));
    end
  endgenerate
endmodule

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] event_in,
  input  logic         stat_we,
  input  logic         en_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] stat,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] stat_q, stat_d, en_q;

  always_comb begin
    stat_d = stat_q;
    if (stat_we) stat_d = stat_d & ~wdata;
    stat_d = stat_d | event_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wdata;
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign irq  = |(stat_q & en_q);

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in != '0) |=> ((stat_q & $past(event_in)) == $past(event_in)));

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter int          DW   = 32,
  parameter int          AW   = 4,
  parameter int          NIRQ = 8,
  parameter logic [31:0] CTRL_RST = 32'h2000_1C8C,
  parameter logic [31:0] MIX_RST  = 32'h00FF_0000,
  parameter logic [31:0] ID_VAL   = 32'h5A17_0C3E
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [NIRQ-1:0] hw_event,
  output logic [DW-1:0]   rsp_rdata,
  output logic            irq,
  output logic [1:0]      fifo_mode
);
  import csr_pkg::*;

  localparam int LANES = 4;
  localparam int BW    = DW / LANES;
  localparam int PAD   = DW - NIRQ;

  logic [NUM_REGS-1:0] wr_hit, rd_hit;
  logic [DW-1:0]       ctrl_v, once_v, mix_v, rc_v, rd_mux, rdata_q;
  logic [NIRQ-1:0]     stat_v, en_v;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign wr_hit[i] = req_valid &  req_write & (req_addr == AW'(i));
      assign rd_hit[i] = req_valid & ~req_write & (req_addr == AW'(i));
    end
  endgenerate

  csr_field #(.W(DW), .RST(CTRL_RST[DW-1:0]), .POL(POL_RW), .RDCLR(1'b0)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[OFS_CTRL]), .wdata(req_wdata),
    .re(1'b0), .value(ctrl_v));

  csr_field #(.W(DW), .RST('0), .POL(POL_WONCE), .RDCLR(1'b0)) u_once (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[OFS_ONCE]), .wdata(req_wdata),
    .re(1'b0), .value(once_v));

  csr_field #(.W(DW), .RST('0), .POL(POL_RW), .RDCLR(1'b1)) u_rdclr (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[OFS_RDCLR]), .wdata(req_wdata),
    .re(rd_hit[OFS_RDCLR]), .value(rc_v));

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_mix
      csr_field #(.W(BW), .RST(MIX_RST[k*BW +: BW]), .POL(mix_lane_policy(k)),
                  .RDCLR(1'b0)) u_lane (
        .clk(clk), .rst_n(rst_n), .we(wr_hit[OFS_MIX]),
        .wdata(req_wdata[k*BW +: BW]), .re(1'b0), .value(mix_v[k*BW +: BW]));
    end
  endgenerate

  csr_irq #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .event_in(hw_event),
    .stat_we(wr_hit[OFS_STAT]), .en_we(wr_hit[OFS_EN]),
    .wdata(req_wdata[NIRQ-1:0]), .stat(stat_v), .en(en_v), .irq(irq));

  always_comb begin
    if      (req_addr == AW'(OFS_CTRL))  rd_mux = ctrl_v;
    else if (req_addr == AW'(OFS_STAT))  rd_mux = {{PAD{1'b0}}, stat_v};
    else if (req_addr == AW'(OFS_EN))    rd_mux = {{PAD{1'b0}}, en_v};
    else if (req_addr == AW'(OFS_ONCE))  rd_mux = once_v;
    else if (req_addr == AW'(OFS_MIX))   rd_mux = mix_v;
    else if (req_addr == AW'(OFS_RDCLR)) rd_mux = rc_v;
    else if (req_addr == AW'(OFS_ID))    rd_mux = ID_VAL[DW-1:0];
    else                                 rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rdata_q <= '0;
    else if (req_valid && !req_write) rdata_q <= rd_mux;
  end

  assign rsp_rdata = rdata_q;
  assign fifo_mode = ctrl_v[29:28];

  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr >= AW'(NUM_REGS))) |=> (rsp_rdata == '0));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (rsp_rdata == $past(rsp_rdata)));

  // R10
  id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit[OFS_ID] |=> (rsp_rdata == ID_VAL[DW-1:0]));
endmodule

// File: tb/csr_bank_tb.sv
module csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic [7:0]  hw_event;
  logic [31:0] rsp_rdata;
  logic        irq;
  logic [1:0]  fifo_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl, m_once, m_mix, m_rc, m_rd;
  logic [7:0]  m_stat, m_en;
  bit          m_once_done;
  localparam logic [31:0] ID = 32'h5A17_0C3E;

  always #2 clk = ~clk;

  csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .hw_event(hw_event),
    .rsp_rdata(rsp_rdata), .irq(irq), .fifo_mode(fifo_mode));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 32'h2000_1C8C; m_once = '0; m_mix = 32'h00FF_0000; m_rc = '0;
    m_rd = '0; m_stat = '0; m_en = '0; m_once_done = 1'b0;
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return {24'd0, m_stat};
      4'd2: return {24'd0, m_en};
      4'd3: return m_once;
      4'd4: return m_mix;
      4'd5: return m_rc;
      4'd6: return ID;
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare(input string tag);
    chk(tag, "rdata", rsp_rdata, m_rd);
    chk(tag, "irq", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
    chk(tag, "fifo_mode", {30'd0, fifo_mode}, {30'd0, m_ctrl[29:28]});
  endtask

  // Called at a negative edge: drive, advance one clock, update model, compare.
  task automatic step(input string tag, input bit v, input bit w,
                      input logic [3:0] a, input logic [31:0] d,
                      input logic [7:0] ev);
    logic [7:0] clr;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; hw_event = ev;
    @(posedge clk);
    @(negedge clk);
    clr = 8'd0;
    if (v && !w) begin
      m_rd = m_read(a);
      if (a == 4'd5) m_rc = '0;
    end
    if (v && w) begin
      case (a)
        4'd0: m_ctrl = d;
        4'd1: clr = d[7:0];
        4'd2: m_en = d[7:0];
        4'd3: if (!m_once_done) begin m_once = d; m_once_done = 1'b1; end
        4'd4: begin
          m_mix[7:0]   = m_mix[7:0]   | d[7:0];
          m_mix[15:8]  = m_mix[15:8]  ^ d[15:8];
          m_mix[23:16] = m_mix[23:16] & d[23:16];
          m_mix[31:24] = m_mix[31:24] ^ ~d[31:24];
        end
        4'd5: m_rc = d;
        default: ;
      endcase
    end
    m_stat = (m_stat & ~clr) | ev;
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [3:0] a, input logic [31:0] d);
    step(tag, 1'b1, 1'b1, a, d, 8'd0);
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    step(tag, 1'b1, 1'b0, a, 32'd0, 8'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; hw_event = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1 reset values
    compare("R1");
    for (int i = 0; i < 7; i++) rd("R1", i[3:0]);

    // R2: strobe low must not write
    step("R2", 1'b0, 1'b1, 4'd0, 32'hDEAD_BEEF, 8'd0);
    rd("R2", 4'd0);
    step("R2", 1'b1, 1'b1, 4'd2, 32'h0000_00FF, 8'd0);
    rd("R2", 4'd0);

    // R4 control word and its mode field
    for (int m = 0; m < 4; m++) begin
      wr("R4", 4'd0, {2'b00, m[1:0], 28'h0ABC_123});
      rd("R4", 4'd0);
    end
    wr("R4", 4'd0, 32'hFFFF_FFFF);
    rd("R4", 4'd0);

    // R3 unmapped offsets, hold behaviour
    wr("R3", 4'd9, 32'h1234_5678);
    for (int i = 7; i < 16; i++) rd("R3", i[3:0]);
    rd("R3", 4'd0);
    step("R3", 1'b0, 1'b0, 4'd6, 32'd0, 8'd0);
    step("R3", 1'b1, 1'b1, 4'd5, 32'h0000_0042, 8'd0);

    // R5 status set and clear, R6 mask
    wr("R6", 4'd2, 32'h0000_0000);
    step("R5", 1'b0, 1'b0, 4'd0, 32'd0, 8'hA5);
    rd("R5", 4'd1);
    wr("R5", 4'd1, 32'h0000_0005);
    rd("R5", 4'd1);
    step("R5", 1'b1, 1'b1, 4'd1, 32'h0000_00A0, 8'h80);
    rd("R5", 4'd1);
    wr("R6", 4'd2, 32'h0000_0001);
    wr("R6", 4'd2, 32'h0000_0080);
    rd("R6", 4'd2);
    wr("R5", 4'd1, 32'h0000_00FF);
    for (int b = 0; b < 8; b++) begin
      wr("R6", 4'd2, 32'(1 << b));
      step("R6", 1'b0, 1'b0, 4'd0, 32'd0, 8'(1 << b));
      wr("R5", 4'd1, 32'(1 << b));
    end

    // R7 write-once
    wr("R7", 4'd3, 32'hCAFE_0001);
    wr("R7", 4'd3, 32'h0000_FFFF);
    rd("R7", 4'd3);

    // R8 modify rules per lane
    wr("R8", 4'd4, 32'h0F_F0_0F_0F);
    rd("R8", 4'd4);
    wr("R8", 4'd4, 32'hF0_3C_33_81);
    rd("R8", 4'd4);
    wr("R8", 4'd4, 32'hFF_FF_FF_00);
    rd("R8", 4'd4);

    // R9 read-to-clear
    wr("R9", 4'd5, 32'h5555_AAAA);
    rd("R9", 4'd5);
    rd("R9", 4'd5);
    wr("R9", 4'd5, 32'h0000_0007);
    rd("R9", 4'd5);

    // R10 read-only identification word
    wr("R10", 4'd6, 32'h0000_0000);
    rd("R10", 4'd6);

    // R11 reset mid-run re-arms write-once
    step("R11", 1'b0, 1'b0, 4'd0, 32'd0, 8'h0F);
    do_reset();
    compare("R11");
    for (int i = 0; i < 7; i++) rd("R11", i[3:0]);
    wr("R11", 4'd3, 32'h0BAD_F00D);
    wr("R11", 4'd3, 32'h1111_1111);
    rd("R11", 4'd3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule